// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches sixteen maskable interrupt request pins and one non-maskable pin. Each maskable pin is synchronised to the clock and then checked against a programmable trigger condition: low level, falling edge, rising edge or either edge. A qualifying event sets a sticky status flag for that line. Software clears the flag through a small register port with a read-then-write-zero handshake. The block drives a per-line request toward a priority controller when both the flag and the line's enable bit are set. It also drives a standby-release output for lines chosen in a separate wake-enable register.

The non-maskable pin has its own edge select. Each selected edge produces a one-cycle request that no enable or mask can block, and the request carries a fixed vector number. Priority arbitration, priority levels and exception sequencing sit outside the block.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset all registers read 0, no request is raised, `wakeup` is 0 and the non-maskable edge select is 0 (falling).
- R2: Line n's two-bit trigger field picks its event: 00 means the pin is low, 01 a falling edge, 10 a rising edge and 11 either edge. Line n's field sits at bits 2n+1:2n of the concatenation {SENSE_HI, SENSE_LO}. An event sets only status bit n.
- R3: A status bit is cleared by writing 0 to it at the STATUS address after a read of STATUS returned it as 1. Writing 1 leaves the bit unchanged, and so does writing 0 without a prior read.
- R4: `irq_req[n]` equals status bit n AND enable bit n. A cleared enable bit does not stop the status flag from being set.
- R5: In low-level mode the flag is set again on every cycle the synchronised pin is low. A clear that lands in the same cycle as a new event leaves the flag set.
- R6: The non-maskable pin raises `nmi_req` for exactly one cycle on each edge of the selected polarity (NMI_SEL bit 0: 1 = rising, 0 = falling). The opposite edge raises nothing, and no enable bit affects it.
- R7: `nmi_vector` reports the value 7.
- R8: `wakeup` is 1 exactly when some line has both its status flag and its wake-enable bit set, whatever the line's enable bit.
- R9: Register addresses are SENSE_LO = 0 (lines 7..0), SENSE_HI = 1 (lines 15..8), ENABLE = 2, STATUS = 3, WAKE = 4 and NMI_SEL = 5. Written values read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 16 | Maskable request pins (idle high) |
| nmi_pin | input | 1 | Non-maskable request pin |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms status clears) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq_req | output | 16 | Per-line masked requests |
| wakeup | output | 1 | Standby-release request |
| nmi_req | output | 1 | One-cycle non-maskable request |
| nmi_vector | output | 8 | Vector number of the non-maskable request |

## Verification
The bench sweeps every line through all four trigger modes. For each mode it drives a falling edge and then a rising edge. It checks which flag bit is set, and it checks that no neighbouring bit is set. This catches a swapped trigger encoding, which would set the flag on the wrong transition, and a misplaced field, which would light another line's bit.

After each event the bench clears the flag. In low-level mode the clear has to fail while the pin is still low, so a design that let the clear win would drop a level interrupt. Separate cases write 1, and write 0 without a prior read. A design with a loose clear handshake would lose a flag in these cases.

For the non-maskable pin, the bench counts pulses for both edge selections. It finds a design that fires on the wrong edge or holds the request longer than one cycle.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_FALL = 2'b01,
      SENSE_RISE = 2'b10,
      SENSE_BOTH = 2'b11
   } sense_e;

   localparam int REG_SENSE_LO = 0;
   localparam int REG_SENSE_HI = 1;
   localparam int REG_ENABLE   = 2;
   localparam int REG_STATUS   = 3;
   localparam int REG_WAKE     = 4;
   localparam int REG_NMI_SEL  = 5;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("irq_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   // pins idle high, so reset the chain to 1 to avoid a spurious low/edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/irq_line_sense.sv
module irq_line_sense
   import ext_irq_pkg::*;
#(
   parameter int NUM_LINES = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_LINES-1:0]   level,
   input  logic [2*NUM_LINES-1:0] sense_cfg,
   output logic [NUM_LINES-1:0]   hit
);
   logic [NUM_LINES-1:0] prev_q;
   logic [NUM_LINES-1:0] fall;
   logic [NUM_LINES-1:0] rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= level;
   end

   assign fall = prev_q & ~level;
   assign rise = ~prev_q & level;

   genvar g;
   generate
      for (g = 0; g < NUM_LINES; g++) begin : g_line
         logic [1:0] mode;
         assign mode   = sense_cfg[2*g +: 2];
         assign hit[g] = (mode == SENSE_LOW)  ? ~level[g] :
                         (mode == SENSE_FALL) ? fall[g]   :
                         (mode == SENSE_RISE) ? rise[g]   :
                                                (fall[g] | rise[g]);
      end
   endgenerate
endmodule

// File: rtl/irq_regs.sv
module irq_regs
   import ext_irq_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int ADDR_W    = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic                   reg_rd,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [NUM_LINES-1:0]   reg_wdata,
   output logic [NUM_LINES-1:0]   reg_rdata,
   input  logic [NUM_LINES-1:0]   hit,
   output logic [2*NUM_LINES-1:0] sense_q,
   output logic [NUM_LINES-1:0]   enable_q,
   output logic [NUM_LINES-1:0]   status_q,
   output logic [NUM_LINES-1:0]   wake_q,
   output logic                   nmi_rise_q
);
   logic [NUM_LINES-1:0] armed_q;
   logic [NUM_LINES-1:0] clr;
   logic                 wr_status;
   logic                 rd_status;

   assign wr_status = reg_wr && (reg_addr == ADDR_W'(REG_STATUS));
   assign rd_status = reg_rd && (reg_addr == ADDR_W'(REG_STATUS));
   assign clr       = wr_status ? (armed_q & ~reg_wdata) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q    <= '0;
         enable_q   <= '0;
         wake_q     <= '0;
         nmi_rise_q <= 1'b0;
      end else if (reg_wr) begin
         case (reg_addr)
            ADDR_W'(REG_SENSE_LO): sense_q[NUM_LINES-1:0]           <= reg_wdata;
            ADDR_W'(REG_SENSE_HI): sense_q[2*NUM_LINES-1:NUM_LINES] <= reg_wdata;
            ADDR_W'(REG_ENABLE):   enable_q                         <= reg_wdata;
            ADDR_W'(REG_WAKE):     wake_q                           <= reg_wdata;
            ADDR_W'(REG_NMI_SEL):  nmi_rise_q                       <= reg_wdata[0];
            default: ;
         endcase
      end
   end

   // new events override a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         armed_q  <= '0;
      end else begin
         status_q <= (status_q & ~clr) | hit;
         if (wr_status)      armed_q <= '0;
         else if (rd_status) armed_q <= armed_q | status_q;
      end
   end

   always_comb begin
      case (reg_addr)
         ADDR_W'(REG_SENSE_LO): reg_rdata = sense_q[NUM_LINES-1:0];
         ADDR_W'(REG_SENSE_HI): reg_rdata = sense_q[2*NUM_LINES-1:NUM_LINES];
         ADDR_W'(REG_ENABLE):   reg_rdata = enable_q;
         ADDR_W'(REG_STATUS):   reg_rdata = status_q;
         ADDR_W'(REG_WAKE):     reg_rdata = wake_q;
         ADDR_W'(REG_NMI_SEL):  reg_rdata = NUM_LINES'(nmi_rise_q);
         default:               reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
   import ext_irq_pkg::*;
#(
   parameter int NUM_LINES   = 16,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int VEC_W       = 8,
   parameter int NMI_VECTOR  = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_pin,
   input  logic                 nmi_pin,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [NUM_LINES-1:0] reg_wdata,
   output logic [NUM_LINES-1:0] reg_rdata,
   output logic [NUM_LINES-1:0] irq_req,
   output logic                 wakeup,
   output logic                 nmi_req,
   output logic [VEC_W-1:0]     nmi_vector
);
   localparam int PIN_W = NUM_LINES + 1;

   generate
      if (NUM_LINES < 2 || NUM_LINES > 32 || (NUM_LINES % 2) != 0) begin : g_bad_lines
         $error("ext_irq_detect: NUM_LINES must be even and within 2..32");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ext_irq_detect: ADDR_W must be at least 3");
      end
      if (NMI_VECTOR >= (1 << VEC_W)) begin : g_bad_vec
         $error("ext_irq_detect: NMI_VECTOR does not fit VEC_W");
      end
   endgenerate

   logic [PIN_W-1:0]       pin_s;
   logic [NUM_LINES-1:0]   hit;
   logic [2*NUM_LINES-1:0] sense_w;
   logic [NUM_LINES-1:0]   enable_w;
   logic [NUM_LINES-1:0]   status_w;
   logic [NUM_LINES-1:0]   wake_w;
   logic                   nmi_rise_w;
   logic                   nmi_prev_q;
   logic                   nmi_hit;
   logic                   nmi_req_q;

   irq_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({nmi_pin, irq_pin}), .q(pin_s)
   );

   irq_line_sense #(.NUM_LINES(NUM_LINES)) u_sense (
      .clk(clk), .rst_n(rst_n), .level(pin_s[NUM_LINES-1:0]),
      .sense_cfg(sense_w), .hit(hit)
   );

   irq_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .hit(hit), .sense_q(sense_w), .enable_q(enable_w), .status_q(status_w),
      .wake_q(wake_w), .nmi_rise_q(nmi_rise_w)
   );

   assign nmi_hit = nmi_rise_w ? (~nmi_prev_q &  pin_s[NUM_LINES])
                               : ( nmi_prev_q & ~pin_s[NUM_LINES]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_prev_q <= 1'b1;
         nmi_req_q  <= 1'b0;
      end else begin
         nmi_prev_q <= pin_s[NUM_LINES];
         nmi_req_q  <= nmi_hit;
      end
   end

   assign nmi_req    = nmi_req_q;
   assign nmi_vector = VEC_W'(NMI_VECTOR);
   assign irq_req    = status_w & enable_w;
   assign wakeup     = |(status_w & wake_w);
endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk
   import ext_irq_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int ADDR_W    = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_req,
   input logic [NUM_LINES-1:0] status_w,
   input logic [NUM_LINES-1:0] enable_w,
   input logic                 wakeup,
   input logic                 nmi_req,
   input logic                 reg_wr,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic [NUM_LINES-1:0] reg_wdata
);
   // R4: a request never appears on a disabled line
   assert_req_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req & ~enable_w) == '0);

   // R3: a flag only falls after a write to the status address
   assert_clear_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(status_w) & ~status_w)) |->
         ($past(reg_wr) && $past(reg_addr) == ADDR_W'(REG_STATUS)));

   // R3: a written 1 never clears a flag
   assert_one_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(status_w) & ~status_w & $past(reg_wdata)) == '0));

   // R6: non-maskable request lasts a single cycle
   assert_nmi_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |=> !nmi_req);

   // R8: wakeup needs a pending flag
   assert_wake_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wakeup |-> (|status_w));
endmodule

bind ext_irq_detect ext_irq_detect_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .status_w(status_w),
   .enable_w(enable_w), .wakeup(wakeup), .nmi_req(nmi_req), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/test_ext_irq_detect.sv
module test_ext_irq_detect;
   localparam logic [15:0] EN_PAT   = 16'hA5A5;
   localparam int          WAKE_LINE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_pin = '1;
   logic        nmi_pin = 1'b1;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [15:0] irq_req;
   logic        wakeup;
   logic        nmi_req;
   logic [7:0]  nmi_vector;

   int n_checks = 0;
   int n_fail   = 0;
   int nmi_cnt  = 0;
   bit done     = 0;

   ext_irq_detect i_ext_irq_detect (
      .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .nmi_pin(nmi_pin),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
      .wakeup(wakeup), .nmi_req(nmi_req), .nmi_vector(nmi_vector)
   );

   always #5 clk = ~clk;

   always @(posedge clk) if (nmi_req) nmi_cnt++;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = 3'(a); reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic clear_line(input int ln);
      logic [15:0] d;
      rd(3, d);
      wr(3, ~(16'd1 << ln));
   endtask

   task automatic check_line(input int ln, input bit exp_flag, input string req);
      logic [15:0] d;
      logic [15:0] exp;
      exp = exp_flag ? (16'd1 << ln) : 16'd0;
      rd(3, d);
      check(d == exp, req, d, exp);
      #1;
      check(irq_req == (exp & EN_PAT), "R4", irq_req, exp & EN_PAT);
      check(wakeup == (exp_flag && ln == WAKE_LINE), "R8", wakeup,
            (exp_flag && ln == WAKE_LINE));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      int c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 6; a++) begin
         rd(a, d);
         check(d == 16'd0, "R1", d, 0);
      end
      check(irq_req == 0 && !wakeup && !nmi_req, "R1",
            {irq_req, 14'd0, wakeup, nmi_req}, 0);
      // R7 vector
      check(nmi_vector == 8'd7, "R7", nmi_vector, 7);

      // R9 register map read-back
      wr(0, 16'h1234); wr(1, 16'hBEEF); wr(2, 16'h0F0F); wr(4, 16'h00FF); wr(5, 16'h0001);
      rd(0, d); check(d == 16'h1234, "R9", d, 16'h1234);
      rd(1, d); check(d == 16'hBEEF, "R9", d, 16'hBEEF);
      rd(2, d); check(d == 16'h0F0F, "R9", d, 16'h0F0F);
      rd(4, d); check(d == 16'h00FF, "R9", d, 16'h00FF);
      rd(5, d); check(d == 16'h0001, "R9", d, 16'h0001);
      rd(3, d); check(d == 16'h0000, "R9", d, 0);

      wr(0, 0); wr(1, 0); wr(2, EN_PAT); wr(4, 16'd1 << WAKE_LINE); wr(5, 0);

      // R2 / R5 / R3 sweep of every line and mode
      for (int ln = 0; ln < 16; ln++) begin
         for (int m = 0; m < 4; m++) begin
            logic [31:0] cfg;
            cfg = 32'(m) << (2 * ln);
            wr(0, cfg[15:0]); wr(1, cfg[31:16]);
            irq_pin[ln] = 1'b0;
            settle();
            check_line(ln, m != 2, "R2 fall");
            clear_line(ln);
            check_line(ln, m == 0, (m == 0) ? "R5" : "R3");
            irq_pin[ln] = 1'b1;
            settle();
            check_line(ln, (m >= 2) || (m == 0), "R2 rise");
            clear_line(ln);
            check_line(ln, 1'b0, "R3");
         end
      end

      // R3 write-1 and write-0-without-read keep the flag
      wr(0, 16'h0001); wr(1, 0);
      irq_pin[0] = 1'b0; settle(); irq_pin[0] = 1'b1; settle();
      wr(3, 16'h0000);
      rd(3, d); check(d == 16'h0001, "R3 no read", d, 1);
      wr(3, 16'hFFFF);
      rd(3, d); check(d == 16'h0001, "R3 write one", d, 1);
      wr(3, 16'hFFFE);
      rd(3, d); check(d == 16'h0000, "R3 armed clear", d, 0);

      // R4 flag set with enable off, request follows enable
      wr(2, 16'h0000);
      irq_pin[0] = 1'b0; settle(); irq_pin[0] = 1'b1; settle();
      rd(3, d); check(d == 16'h0001, "R4 flag", d, 1);
      #1 check(irq_req == 0, "R4 masked", irq_req, 0);
      wr(2, 16'h0001);
      #1 check(irq_req == 16'h0001, "R4 enabled", irq_req, 1);
      // R8 wakeup independent of enable
      wr(2, 16'h0000); wr(4, 16'h0001);
      #1 check(wakeup == 1'b1, "R8", wakeup, 1);
      clear_line(0);

      // R6 non-maskable edges
      wr(5, 0);
      c0 = nmi_cnt; nmi_pin = 1'b0; settle();
      check(nmi_cnt - c0 == 1, "R6 fall sel", nmi_cnt - c0, 1);
      c0 = nmi_cnt; nmi_pin = 1'b1; settle();
      check(nmi_cnt - c0 == 0, "R6 rise ignored", nmi_cnt - c0, 0);
      wr(5, 1);
      c0 = nmi_cnt; nmi_pin = 1'b0; settle();
      check(nmi_cnt - c0 == 0, "R6 fall ignored", nmi_cnt - c0, 0);
      c0 = nmi_cnt; nmi_pin = 1'b1; settle();
      check(nmi_cnt - c0 == 1, "R6 rise sel", nmi_cnt - c0, 1);
      check(nmi_vector == 8'd7, "R7", nmi_vector, 7);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule